// File: doc/BRIEF.md
# Host Session Request Detector

This block sits on the host side of a dual-role USB port and looks after port power. It also listens for a remote device that asks for a new session. Software uses a small register interface to set the port power and port suspend bits. The power bit drives a port power output towards the PHY. While the port is unpowered and the PHY reports VBUS as not valid, the block watches the D+ and D- line states for a pulse driven by the remote device.

A pulse counts as a session request only if its length, measured in ticks of a millisecond strobe, falls inside a window. The defaults are at least 4 ms and at most 11 ms. Short glitches and a pull-up that stays on are both turned away. An accepted pulse latches a session-request flag. Software clears the flag by writing 1 to it, and the flag reaches the interrupt output only while its enable bit is set.

Software answers the interrupt by turning port power back on. Once the PHY reports VBUS valid and a pull-up shows on either data line, the block reports the device as connected, which completes the session request.

Top module: `sess_req_detector`

## Requirements
- R1: After reset, port_pwr_o, port_susp_o, irq_o and connected_o are 0, and the session-request flag (register 1, bit 0) reads 0.
- R2: A write to register 0 sets the port power bit from data bit 0 and the port suspend bit from data bit 1. These bits appear on port_pwr_o and port_susp_o on the clock after the write.
- R3: While detection is armed, a high level on the data lines that spans 4 to 11 millisecond ticks, both ends included, sets the session-request flag (register 1, bit 0) on the clock after the line falls.
- R4: A high level that spans fewer than 4 ticks, or more than 11 ticks, leaves the flag clear.
- R5: Detection is armed only while the port power bit is 0 and vbus_valid is 0. A pulse of valid length leaves the flag clear when either condition fails.
- R6: Writing register 1 with data bit 0 set clears the flag. Writing register 1 with data bit 0 clear leaves the flag unchanged.
- R7: irq_o is high exactly when the flag is set and the enable bit (register 2, bit 0) is set.
- R8: connected_o goes high one clock after the port power bit, vbus_valid and (line_dp or line_dm) are all high, and it reads back as register 0, bit 2. It stays low when vbus_valid is low.
- R9: A pulse on line_dm alone qualifies in the same way as a pulse on line_dp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| vbus_valid | input | 1 | VBUS valid indication from the PHY |
| line_dp | input | 1 | Sampled D+ line state |
| line_dm | input | 1 | Sampled D- line state |
| port_pwr_o | output | 1 | Port power request to the PHY |
| port_susp_o | output | 1 | Port suspend state |
| connected_o | output | 1 | Device connected after power-up |
| irq_o | output | 1 | Session-request interrupt |

## Verification
The bench builds the block with its default window of 4 to 11 ms and strobes ms_tick every fourth clock. At that rate even a 20 ms over-long pulse takes only about eighty cycles. Both window edges, the ticks on either side of them, the saturated counter and the two disarm conditions can therefore all be reached in a short run. Data width stays at 8, which leaves the unused read bits observable as zero.

// File: rtl/sreq_pkg.sv
package sreq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORT = 2'd0,
    REG_IRQ  = 2'd1,
    REG_IEN  = 2'd2
  } reg_addr_e;

  localparam int BIT_PWR  = 0;
  localparam int BIT_SUSP = 1;
  localparam int BIT_CONN = 2;
  localparam int BIT_SREQ = 0;
  localparam int BIT_IEN  = 0;

  // True when a measured length in ms lies inside the accepted window.
  function automatic logic in_window(input int unsigned ms,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (ms >= lo) && (ms <= hi);
  endfunction

  // Saturating increment used by the millisecond counter.
  function automatic int unsigned sat_inc(input int unsigned v,
                                          input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/sreq_regs.sv
module sreq_regs
  import sreq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              set_sreq,
  input  logic              conn_in,
  output logic              pwr_q,
  output logic              susp_q,
  output logic              flag_q,
  output logic              ien_q
);
  logic wr_port, wr_irq, wr_ien;

  assign wr_port = wr_en && (wr_addr == REG_PORT);
  assign wr_irq  = wr_en && (wr_addr == REG_IRQ);
  assign wr_ien  = wr_en && (wr_addr == REG_IEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      susp_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_port) begin
        pwr_q  <= wr_data[BIT_PWR];
        susp_q <= wr_data[BIT_SUSP];
      end
      if (wr_ien) ien_q <= wr_data[BIT_IEN];
    end
  end

  // A new request wins over a simultaneous clear so none is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          flag_q <= 1'b0;
    else if (set_sreq)                   flag_q <= 1'b1;
    else if (wr_irq && wr_data[BIT_SREQ]) flag_q <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_PORT: begin
        rd_data[BIT_PWR]  = pwr_q;
        rd_data[BIT_SUSP] = susp_q;
        rd_data[BIT_CONN] = conn_in;
      end
      REG_IRQ: rd_data[BIT_SREQ] = flag_q;
      REG_IEN: rd_data[BIT_IEN]  = ien_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sreq_pulse_timer.sv
module sreq_pulse_timer
  import sreq_pkg::*;
#(
  parameter int MIN_MS = 4,
  parameter int MAX_MS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic line_hi,
  input  logic ms_tick,
  output logic pulse_ok
);
  localparam int SAT   = MAX_MS + 1;
  localparam int CNT_W = $clog2(SAT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             line_q;
  logic             fall_w;

  assign fall_w   = arm && line_q && !line_hi;
  assign pulse_ok = fall_w && in_window(32'(cnt_q), MIN_MS, MAX_MS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      line_q <= 1'b0;
    end else if (!arm) begin
      cnt_q  <= '0;
      line_q <= 1'b0;
    end else begin
      line_q <= line_hi;
      if (!line_hi)     cnt_q <= '0;
      else if (ms_tick) cnt_q <= CNT_W'(sat_inc(32'(cnt_q), SAT));
    end
  end
endmodule

// File: rtl/sreq_conn_mon.sv
module sreq_conn_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr,
  input  logic vbus_valid,
  input  logic line_hi,
  output logic connected
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) connected <= 1'b0;
    else        connected <= pwr && vbus_valid && line_hi;
  end
endmodule

// File: rtl/sess_req_detector.sv
module sess_req_detector
  import sreq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_MS = 4,
  parameter int MAX_MS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              vbus_valid,
  input  logic              line_dp,
  input  logic              line_dm,
  output logic              port_pwr_o,
  output logic              port_susp_o,
  output logic              connected_o,
  output logic              irq_o
);
  logic pwr_q, susp_q, flag_q, ien_q;
  logic line_hi_w, arm_w, pulse_ok_w, conn_w;

  assign line_hi_w = line_dp || line_dm;
  assign arm_w     = !pwr_q && !vbus_valid;

  sreq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .set_sreq(pulse_ok_w), .conn_in(conn_w),
    .pwr_q(pwr_q), .susp_q(susp_q), .flag_q(flag_q), .ien_q(ien_q)
  );

  sreq_pulse_timer #(.MIN_MS(MIN_MS), .MAX_MS(MAX_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(arm_w), .line_hi(line_hi_w),
    .ms_tick(ms_tick), .pulse_ok(pulse_ok_w)
  );

  sreq_conn_mon u_conn (
    .clk(clk), .rst_n(rst_n), .pwr(pwr_q), .vbus_valid(vbus_valid),
    .line_hi(line_hi_w), .connected(conn_w)
  );

  assign port_pwr_o  = pwr_q;
  assign port_susp_o = susp_q;
  assign connected_o = conn_w;
  assign irq_o       = flag_q && ien_q;
endmodule

// File: rtl/sreq_checker.sv
module sreq_checker
  import sreq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       port_pwr_o,
  input logic       vbus_valid,
  input logic       sreq_flag,
  input logic       pulse_ok,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       wr_bit0,
  input logic       connected_o,
  input logic       irq_o
);
  // R3: the flag only rises after a qualified pulse
  p_rise_after_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sreq_flag) |-> $past(pulse_ok));

  // R5: no request is taken while powered or with VBUS valid
  p_armed_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sreq_flag) |-> $past(!port_pwr_o && !vbus_valid));

  // R6: the flag only falls by a write of 1 to the interrupt register
  p_w1c_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sreq_flag) |-> $past(wr_en && wr_addr == REG_IRQ && wr_bit0));

  // R7: interrupt needs a pending flag
  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> sreq_flag);

  // R8: connect follows powered port with valid VBUS
  p_conn_powered_r8: assert property (@(posedge clk) disable iff (!rst_n)
    connected_o |-> $past(port_pwr_o && vbus_valid));
endmodule

bind sess_req_detector sreq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .port_pwr_o(port_pwr_o), .vbus_valid(vbus_valid),
  .sreq_flag(flag_q), .pulse_ok(pulse_ok_w), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_bit0(wr_data[0]), .connected_o(connected_o),
  .irq_o(irq_o)
);

// File: tb/sess_req_detector_bench.sv
module sess_req_detector_bench;
  localparam int DATA_W = 8;
  localparam int LO_MS  = 4;
  localparam int HI_MS  = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic vbus_valid = 1'b0, line_dp = 1'b0, line_dm = 1'b0;
  logic port_pwr_o, port_susp_o, connected_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sess_req_detector #(.DATA_W(DATA_W), .MIN_MS(LO_MS), .MAX_MS(HI_MS)) u_sess_req_detector (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .vbus_valid(vbus_valid), .line_dp(line_dp), .line_dm(line_dm),
    .port_pwr_o(port_pwr_o), .port_susp_o(port_susp_o),
    .connected_o(connected_o), .irq_o(irq_o)
  );

  // Rows: [10:3] pulse length in ms, [2] power bit, [1] vbus_valid, [0] expected flag
  localparam int NV = 9;
  localparam logic [10:0] VECS [NV] = '{
    {8'd2,  1'b0, 1'b0, 1'b0},
    {8'd3,  1'b0, 1'b0, 1'b0},
    {8'd4,  1'b0, 1'b0, 1'b1},
    {8'd7,  1'b0, 1'b0, 1'b1},
    {8'd11, 1'b0, 1'b0, 1'b1},
    {8'd12, 1'b0, 1'b0, 1'b0},
    {8'd20, 1'b0, 1'b0, 1'b0},
    {8'd6,  1'b1, 1'b0, 1'b0},
    {8'd6,  1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [DATA_W-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic tick_ms();
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_pulse(input int n, input bit use_dm);
    @(negedge clk);
    if (use_dm) line_dm = 1'b1; else line_dp = 1'b1;
    for (int i = 0; i < n; i++) tick_ms();
    @(negedge clk);
    line_dp = 1'b0; line_dm = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] rv;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pwr", port_pwr_o, 0);
    check("R1 susp", port_susp_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 conn", connected_o, 0);
    reg_read(2'd1, rv); check("R1 flag", rv, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R3 accepted lengths, R4 rejected lengths, R5 disarmed
    for (int v = 0; v < NV; v++) begin
      int ms;
      logic pw, vb, ex;
      ms = int'(VECS[v][10:3]); pw = VECS[v][2]; vb = VECS[v][1]; ex = VECS[v][0];
      reg_write(2'd0, {6'd0, 1'b0, pw});
      @(negedge clk); vbus_valid = vb;
      send_pulse(ms, 1'b0);
      reg_read(2'd1, rv);
      if (ex)            check("R3 window accept", rv[0], 1);
      else if (pw || vb) check("R5 disarmed", rv[0], 0);
      else               check("R4 out of window", rv[0], 0);
      vbus_valid = 1'b0;
      reg_write(2'd1, 8'h01);
      reg_write(2'd0, 8'h00);
    end

    // R2: port control write
    reg_write(2'd0, 8'h02);
    check("R2 pwr off", port_pwr_o, 0);
    check("R2 susp on", port_susp_o, 1);

    // R9: pulse on D- alone
    send_pulse(5, 1'b1);
    reg_read(2'd1, rv); check("R9 dm pulse", rv[0], 1);

    // R7: gated by enable
    check("R7 irq masked", irq_o, 0);
    reg_write(2'd2, 8'h01);
    check("R7 irq enabled", irq_o, 1);

    // R6: write 0 keeps, write 1 clears
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, rv); check("R6 write0 keeps", rv[0], 1);
    reg_write(2'd1, 8'h01);
    reg_read(2'd1, rv); check("R6 write1 clears", rv[0], 0);
    check("R7 irq after clear", irq_o, 0);

    // R2/R8: software restores power, device connects
    reg_write(2'd0, 8'h01);
    check("R2 pwr on", port_pwr_o, 1);
    check("R2 susp cleared", port_susp_o, 0);
    line_dp = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 no vbus no conn", connected_o, 0);
    vbus_valid = 1'b1;
    @(negedge clk);
    check("R8 connected", connected_o, 1);
    reg_read(2'd0, rv); check("R8 conn readback", rv[2], 1);
    reg_read(2'd1, rv); check("R5 no request when powered", rv[0], 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule